// File: doc/BRIEF.md
# Partitioned-Table Multiplier-Free FIR Inner Product

This block computes one output of a fixed-coefficient FIR sub-filter: the signed sum of K coefficients, each multiplied by its own W-bit two's-complement sample. It uses no multipliers. The coefficients are an elaboration-time parameter. Taps whose coefficient is zero are dropped. The remaining taps are split into groups of at most `GS` taps. For each group, every possible bit pattern across that group's samples has a precomputed table entry, and that entry is the sum of the coefficients whose sample bit is one.

Every bit position of the input word has its own copy of the group tables, so a full result is formed on each clock. Bit slice r is weighted by 2^r. The top bit carries the negative weight of two's-complement form, so its slice is subtracted rather than added. A registered binary adder tree then combines all weighted slices. New samples may be presented on every cycle. Each result appears a fixed number of cycles later, together with a valid flag that tracks the input flag.

The pipeline has no state machine. It is a fixed chain of register stages:

1. input capture
2. table lookup
3. slice weighting
4. one stage per adder-tree level

Top module: `da_fir_core`

## Requirements
- R1: While reset is asserted and after its release, before any sample has propagated, `valid_o` is 0 and `y_o` is 0. When the samples have been all zero for longer than the pipeline depth, `y_o` is 0.
- R2: `y_o` equals the exact sum over k of c_k·x_k. Tap k's sample is `x_i[k*W +: W]` and its coefficient is `COEFS[k*CW +: CW]`, both signed two's complement.
- R3: A sample captured at a rising edge produces its result after LAT further rising edges. LAT = 3 + ceil(log2(W·G)), where G is the number of groups. With the defaults, LAT is 7.
- R4: `valid_o` is `valid_i` delayed by exactly LAT cycles. Every accepted sample yields exactly one result, in order.
- R5: A new sample can be accepted on every cycle. Back-to-back results are independent of their neighbours.
- R6: Bit W-1 of a sample carries weight −2^(W−1). A sample with only its top bit set produces −c·2^(W−1).
- R7: A tap with a zero coefficient has no effect on `y_o`, whatever its sample.
- R8: The result does not depend on how the nonzero taps are grouped. A configuration with two groups of unequal size gives exact results over all input combinations.
- R9: The output width AW = CW + W + ceil(log2 K) holds the full-precision result. With all samples at their extremes the output does not wrap, and |y| never exceeds Σ|c_k|·2^(W−1).
- R10: While the inputs are held constant, `y_o` is constant once the pipeline has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Marks the samples on `x_i` as a real input |
| x_i | input | K·W | K packed signed samples, tap k at bits k·W upward |
| valid_o | output | 1 | Marks `y_o` as the result of a valid input |
| y_o | output | AW | Signed full-precision inner product |

## Verification
The corner cases are the extremes of the sample range, where a design that forgets to subtract the sign slice reports +c·2^(W−1) instead of −c·2^(W−1), or wraps on an undersized accumulator. Single-bit walks across every tap and bit expose a mis-wired table address or a wrong shift amount. A zero-coefficient tap is varied while the others are held fixed. A design that kept a zero tap in a table, or that misaligned the remaining tap indices after dropping it, would show a changing or wrong output. A second, small configuration with two unequal groups is swept over every input combination, so that an error in group sizing or in table entries is caught. The latency and the valid flag are timed with a single isolated sample, which catches a missing or extra pipeline stage.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int tree_depth(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

endpackage

// File: rtl/da_lut_slice.sv
module da_lut_slice #(
    parameter int GN = 4,
    parameter int GMAX = 4,
    parameter int CW = 14,
    parameter int OW = 28,
    parameter logic [GMAX*CW-1:0] COEFS = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GN-1:0]        addr,
    output logic signed [OW-1:0] q
);
    localparam int DEPTH = 1 << GN;

    function automatic logic signed [OW-1:0] entry(input int a);
        logic signed [OW-1:0] s;
        logic [CW-1:0] c;
        s = '0;
        for (int i = 0; i < GN; i++) begin
            c = COEFS[i*CW +: CW];
            if (a[i]) s = s + {{(OW-CW){c[CW-1]}}, c};
        end
        return s;
    endfunction

    logic signed [OW-1:0] tbl [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_ent
        assign tbl[a] = entry(a);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= tbl[addr];
    end
endmodule

// File: rtl/da_adder_tree.sv
module da_adder_tree
    import da_fir_pkg::*;
#(
    parameter int N = 12,
    parameter int AW = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [AW-1:0] leaf [N],
    output logic signed [AW-1:0] sum
);
    localparam int L  = tree_depth(N);
    localparam int NP = 1 << L;

    logic signed [AW-1:0] leafv [NP];

    for (genvar i = 0; i < NP; i++) begin : g_pad
        if (i < N) begin : g_real
            assign leafv[i] = leaf[i];
        end else begin : g_zero
            assign leafv[i] = '0;
        end
    end

    if (L == 0) begin : g_flat
        assign sum = leafv[0];
    end else begin : g_tree
        logic signed [AW-1:0] inner [NP];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int n = 0; n < NP; n++) inner[n] <= '0;
            end else begin
                inner[0] <= '0;
                for (int n = NP/2; n < NP; n++)
                    inner[n] <= leafv[2*n-NP] + leafv[2*n+1-NP];
                for (int n = 1; n < NP/2; n++)
                    inner[n] <= inner[2*n] + inner[2*n+1];
            end
        end
        assign sum = inner[1];
    end
endmodule

// File: rtl/da_fir_core.sv
module da_fir_core
    import da_fir_pkg::*;
#(
    parameter int K  = 4,
    parameter int W  = 12,
    parameter int CW = 14,
    parameter int GS = 4,
    parameter logic [K*CW-1:0] COEFS = {14'(-3001), 14'(0), 14'(-8192), 14'(8191)},
    localparam int AW = CW + W + $clog2(K)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [K*W-1:0] x_i,
    output logic          valid_o,
    output logic [AW-1:0] y_o
);
    function automatic int count_nz();
        int n;
        n = 0;
        for (int k = 0; k < K; k++)
            if (COEFS[k*CW +: CW] != '0) n++;
        return n;
    endfunction

    function automatic int nz_tap(input int j);
        int n;
        int idx;
        n = 0;
        idx = 0;
        for (int k = 0; k < K; k++) begin
            if (COEFS[k*CW +: CW] != '0) begin
                if (n == j) idx = k;
                n++;
            end
        end
        return idx;
    endfunction

    function automatic logic [GS*CW-1:0] group_coefs(input int base, input int gsz);
        logic [GS*CW-1:0] v;
        v = '0;
        for (int i = 0; i < gsz; i++)
            v[i*CW +: CW] = COEFS[nz_tap(base+i)*CW +: CW];
        return v;
    endfunction

    localparam int NZ  = count_nz();
    localparam int NG  = ceil_div(NZ, GS);
    localparam int NT  = W * NG;
    localparam int LAT = 3 + tree_depth(NT);

    logic [K*W-1:0]       xq;
    logic [LAT-1:0]       vpipe;
    logic signed [AW-1:0] lut_q [NT];
    logic signed [AW-1:0] term  [NT];
    logic signed [AW-1:0] tree_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xq    <= '0;
            vpipe <= '0;
        end else begin
            xq    <= x_i;
            vpipe <= {vpipe[LAT-2:0], valid_i};
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int BASE = g * GS;
        localparam int GSZ  = (NZ - BASE < GS) ? (NZ - BASE) : GS;
        localparam logic [GS*CW-1:0] GC = group_coefs(BASE, GSZ);
        for (genvar r = 0; r < W; r++) begin : g_bit
            logic [GSZ-1:0] addr;
            for (genvar i = 0; i < GSZ; i++) begin : g_tap
                localparam int TAP = nz_tap(BASE + i);
                assign addr[i] = xq[TAP*W + r];
            end
            da_lut_slice #(
                .GN(GSZ), .GMAX(GS), .CW(CW), .OW(AW), .COEFS(GC)
            ) u_lut (
                .clk(clk), .rst_n(rst_n), .addr(addr), .q(lut_q[g*W + r])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) term[t] <= '0;
        end else begin
            for (int t = 0; t < NT; t++)
                term[t] <= ((t % W) == W - 1) ? -(lut_q[t] <<< (t % W))
                                              :  (lut_q[t] <<< (t % W));
        end
    end

    da_adder_tree #(.N(NT), .AW(AW)) u_tree (
        .clk(clk), .rst_n(rst_n), .leaf(term), .sum(tree_sum)
    );

    assign y_o     = tree_sum;
    assign valid_o = vpipe[LAT-1];
endmodule

// File: rtl/da_fir_core_chk.sv
module da_fir_core_chk #(
    parameter int K = 4,
    parameter int W = 12,
    parameter int CW = 14,
    parameter int AW = 28,
    parameter int LAT = 7,
    parameter logic [K*CW-1:0] COEFS = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic [K*W-1:0] x_i,
    input logic          valid_o,
    input logic [AW-1:0] y_o
);
    function automatic longint bound();
        longint s;
        longint c;
        s = 0;
        for (int k = 0; k < K; k++) begin
            c = longint'($signed(COEFS[k*CW +: CW]));
            s = s + ((c < 0) ? -c : c);
        end
        return s * (longint'(1) << (W - 1));
    endfunction

    localparam longint BOUND = bound();

    logic [LAT-1:0] vsh;
    logic [K*W-1:0] prev_x;
    int             cnt;
    longint         ys;

    assign ys = longint'($signed(y_o));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsh    <= '0;
            prev_x <= '0;
            cnt    <= 0;
        end else begin
            vsh    <= {vsh[LAT-2:0], valid_i};
            prev_x <= x_i;
            cnt    <= (x_i == prev_x) ? ((cnt < 1000) ? cnt + 1 : cnt) : 0;
        end
    end

    // R4
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == vsh[LAT-1]);

    // R9
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((ys <= BOUND) && (ys >= -BOUND)));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > LAT + 2) |-> $stable(y_o));

    // R1
    zero_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt > LAT + 2) && (prev_x == '0)) |-> (y_o == '0));

    // R4
    valid_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(valid_o));
endmodule

bind da_fir_core da_fir_core_chk #(
    .K(K), .W(W), .CW(CW), .AW(AW), .LAT(LAT), .COEFS(COEFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .x_i(x_i),
    .valid_o(valid_o), .y_o(y_o)
);

// File: tb/da_fir_core_test.sv
`timescale 1ns/1ps
module da_fir_core_test;
    localparam int KB = 4, WB = 12, AWB = 28;
    localparam int CB [KB] = '{8191, -8192, 0, -3001};
    localparam int KS = 4, WS = 4, CWS = 5, AWS = 11;
    localparam int CS [KS] = '{7, -16, 0, 11};
    localparam logic [KS*CWS-1:0] COEF_S = {5'(11), 5'(0), 5'(-16), 5'(7)};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vb = 1'b0, vs = 1'b0;
    logic [KB*WB-1:0] xb = '0;
    logic [KS*WS-1:0] xs = '0;
    logic vob, vos;
    logic [AWB-1:0] yb;
    logic [AWS-1:0] ys;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    longint qb[$];
    string  tagq[$];
    longint qs[$];

    always #2.5 clk = ~clk;

    da_fir_core uut (
        .clk(clk), .rst_n(rst_n), .valid_i(vb), .x_i(xb), .valid_o(vob), .y_o(yb)
    );

    da_fir_core #(.K(KS), .W(WS), .CW(CWS), .GS(2), .COEFS(COEF_S)) uut_small (
        .clk(clk), .rst_n(rst_n), .valid_i(vs), .x_i(xs), .valid_o(vos), .y_o(ys)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint eb(input logic [KB*WB-1:0] x);
        longint s = 0;
        for (int k = 0; k < KB; k++)
            s += longint'(CB[k]) * longint'($signed(x[k*WB +: WB]));
        return s;
    endfunction

    function automatic longint es(input logic [KS*WS-1:0] x);
        longint s = 0;
        for (int k = 0; k < KS; k++)
            s += longint'(CS[k]) * longint'($signed(x[k*WS +: WS]));
        return s;
    endfunction

    function automatic logic [KB*WB-1:0] pk(input int a, input int b, input int c, input int d);
        return {WB'(d), WB'(c), WB'(b), WB'(a)};
    endfunction

    task automatic drive_b(input logic [KB*WB-1:0] x, input string tag);
        xb = x;
        vb = 1'b1;
        qb.push_back(eb(x));
        tagq.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle_b(input int n);
        vb = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (vob) begin
                if (qb.size() == 0) chk("R4 unexpected valid (big)", 1, 0);
                else chk(tagq.pop_front(), longint'($signed(yb)), qb.pop_front());
            end
            if (vos) begin
                if (qs.size() == 0) chk("R4 unexpected valid (small)", 1, 0);
                else chk("R8 exhaustive two-group", longint'($signed(ys)), qs.pop_front());
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        int n;
        int ext [4];
        ext = '{-2048, 2047, 0, -1};
        xb = pk(100, -200, 300, -400);
        vb = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 reset y", longint'(yb), 0);
        chk("R1 reset valid", longint'(vob), 0);
        chk("R1 reset valid small", longint'(vos), 0);
        vb = 1'b0;
        xb = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release y", longint'(yb), 0);
        chk("R1 after release valid", longint'(vob), 0);
        idle_b(10);
        chk("R1 zero input y", longint'(yb), 0);

        // R3 / R4 latency with a single sample
        xb = pk(1234, -567, 89, -1011);
        vb = 1'b1;
        qb.push_back(eb(xb));
        tagq.push_back("R3 latency value");
        @(negedge clk);
        vb = 1'b0;
        n = 1;
        while (!vob && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R3 latency cycles", n, 7);
        @(negedge clk);
        chk("R4 single valid pulse", longint'(vob), 0);
        idle_b(10);

        // R6 walking single bits over every tap and bit slice
        for (int k = 0; k < KB; k++)
            for (int b = 0; b < WB; b++)
                drive_b((KB*WB)'(1) << (k*WB + b), "R6 bit slice walk");
        idle_b(3);

        // R9 extremes on all taps
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++)
                        drive_b(pk(ext[a], ext[b], ext[c], ext[d]), "R9 extreme values");
        idle_b(2);

        // R7 zero-coefficient tap varied, others fixed
        for (int i = 0; i < 40; i++)
            drive_b(pk(-777, 1500, (i * 211) - 2048, 333), "R7 zero tap ignored");
        idle_b(2);

        // R5 back-to-back random stream
        for (int i = 0; i < 3000; i++)
            drive_b((KB*WB)'({$urandom, $urandom}), "R5 random stream");

        // R2 random with gaps in valid
        for (int i = 0; i < 500; i++) begin
            drive_b((KB*WB)'({$urandom, $urandom}), "R2 random gapped");
            if ((i % 3) == 0) idle_b(1 + (i % 4));
        end

        // R10 inputs held constant
        for (int i = 0; i < 25; i++)
            drive_b(pk(-2048, -2048, 5, 2047), "R10 held input");
        idle_b(12);
        chk("R4 big results delivered", qb.size(), 0);

        // R8 exhaustive sweep of the two-group configuration
        for (int v = 0; v < (1 << (KS*WS)); v++) begin
            xs = (KS*WS)'(v);
            vs = 1'b1;
            qs.push_back(es(xs));
            @(negedge clk);
        end
        vs = 1'b0;
        repeat (12) @(negedge clk);
        chk("R8 small results delivered", qs.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule